// File: doc/BRIEF.md
# SPI Flash Streaming Read Engine

This block is the master side of a serial NOR flash read. The host places a 24-bit start address and a byte count on its inputs and pulses `start`. The engine then runs the whole read on its own. It pulls chip select low and shifts out the plain read opcode and the three address bytes. It then sends one filler byte for each data byte the host asked for. The serial clock follows mode 0: it idles low, the master changes its output on the falling edge, and the input line is sampled on the rising edge.

Every byte shifted out brings one byte back. The four bytes that return while the command and address go out carry no data, so they are dropped. Each byte that returns during the filler phase is placed on an 8-bit valid/ready stream. A single output register holds the byte until it is taken. The next filler byte is only started when that register is free, or is being emptied in the same cycle. A slow consumer therefore halts the serial clock, low, between bytes and no byte is lost. When the count is used up, chip select returns high and a one-cycle `done` follows. A zero count finishes at once and never touches the serial lines.

Top module: `flash_stream_reader`

## Requirements
- R1: While reset is held and in the first cycle after it, `csN` is 1 and `sclk`, `busy`, `done` and `dataValid` are all 0.
- R2: A read with a nonzero count lowers `csN` before the first rising edge of `sclk`. The first 32 bits on `mosi` are the opcode 0x03 and then the start address, most significant address byte first, each byte MSB first. `mosi` only changes while `sclk` is low, and `sclk` never rises while `csN` is high.
- R3: The bytes on `miso` during the 32 command bits are never presented. The first byte on the stream is the byte at the start address.
- R4: While `csN` is low, `sclk` has exactly 8*(4+count) rising edges, and every bit sent after the address is 0 (filler byte 0x00).
- R5: The stream carries, in order, the bytes at start address + k for k = 0..count-1, with the address wrapping modulo 2^24. While `dataValid` is 1 and `dataReady` is 0, `dataValid` stays 1 and `dataOut` holds its value.
- R6: Back-pressure loses no byte. Exactly count bytes are delivered. While the output register holds an unaccepted byte, no further byte is clocked: `sclk` stays low and gains no rising edge.
- R7: After the last byte, `csN` returns high. `done` is 1 for exactly one cycle, in the cycle after the first cycle with `csN` high, and `busy` is 0 in that cycle.
- R8: A start with a count of 0 gives `done` = 1 in the next cycle, and `csN` never goes low.
- R9: A start that arrives while `busy` is 1 is ignored. The running read keeps its address and count, and no second chip-select period follows.
- R10: `sclk` is high for CLK_DIV/2 system cycles per bit, and the shortest gap between rising edges within a byte is CLK_DIV cycles (CLK_DIV even, at least 2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to begin a read |
| startAddr | input | ADDR_W (24) | First byte address, sampled with start |
| byteCount | input | COUNT_W (16) | Number of data bytes, sampled with start |
| busy | output | 1 | High from the accepted start until done |
| done | output | 1 | One-cycle completion pulse |
| csN | output | 1 | Flash chip select, active low |
| sclk | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data to the flash |
| miso | input | 1 | Serial data from the flash |
| dataOut | output | 8 | Received data byte |
| dataValid | output | 1 | dataOut holds a byte not yet taken |
| dataReady | input | 1 | Consumer takes dataOut when high with dataValid |

## Verification
Two events can land on the same cycle. One is the decision in the gap between bytes to launch the next filler byte. The other is the consumer taking the byte held in the output register. The launch is allowed in exactly that cycle, so a wrong gate either overwrites a pending byte or stalls forever. The bench provokes this by toggling `dataReady` at random on every cycle, and also by one long hold-off followed by release. It judges the result by comparing the whole stream with a flash model and by counting the clock edges in the chip-select period. Two checks also fire on any deposit into a full register and on any change of a held byte.

// File: rtl/fsr_pkg.sv
package fsr_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SHIFT,
    ST_GAP,
    ST_FIN
  } fsr_state_t;

  // Strobes from the sequencer to the shift datapath, valid for one cycle.
  typedef struct packed {
    logic       loadByte;  // start shifting txByte now
    logic [7:0] txByte;    // byte to shift out
    logic       csLow;     // open the command
    logic       csHigh;    // close the command
    logic       keepByte;  // copy the finished receive byte to the output
  } fsr_strobe_t;

endpackage

// File: rtl/fsr_ctrl.sv
module fsr_ctrl
  import fsr_pkg::*;
#(
  parameter int         ADDR_W    = 24,
  parameter int         COUNT_W   = 16,
  parameter logic [7:0] READ_OP   = 8'h03,
  parameter logic [7:0] FILL_BYTE = 8'h00
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [ADDR_W-1:0]  startAddr,
  input  logic [COUNT_W-1:0] byteCount,
  input  logic               byteDone,
  input  logic               slotFree,
  output fsr_strobe_t        strobe,
  output logic               busy,
  output logic               done
);

  localparam int ADDR_BYTES = ADDR_W / 8;
  localparam int CMD_BYTES  = ADDR_BYTES + 1;
  localparam int IDX_W      = $clog2(CMD_BYTES + 1);
  localparam logic [IDX_W-1:0] DATA_IDX = IDX_W'(CMD_BYTES);

  fsr_state_t         state;
  logic [IDX_W-1:0]   cmdIdx;   // index of the byte in flight; DATA_IDX in data phase
  logic [ADDR_W-1:0]  addrSh;   // address bytes still to send, top byte next
  logic [COUNT_W-1:0] dataLeft;
  logic               doneReg;

  assign busy = (state != ST_IDLE);
  assign done = doneReg;

  always_comb begin
    strobe = '0;
    unique case (state)
      ST_IDLE: begin
        if (start && (byteCount != '0)) begin
          strobe.csLow    = 1'b1;
          strobe.loadByte = 1'b1;
          strobe.txByte   = READ_OP;
        end
      end
      ST_SHIFT: begin
        if (byteDone && (cmdIdx == DATA_IDX)) begin
          strobe.keepByte = 1'b1;
          if (dataLeft == COUNT_W'(1)) strobe.csHigh = 1'b1;
        end
      end
      ST_GAP: begin
        if (cmdIdx != DATA_IDX) begin
          strobe.loadByte = 1'b1;
          strobe.txByte   = addrSh[ADDR_W-1 -: 8];
        end else if (slotFree) begin
          strobe.loadByte = 1'b1;
          strobe.txByte   = FILL_BYTE;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cmdIdx   <= '0;
      addrSh   <= '0;
      dataLeft <= '0;
      doneReg  <= 1'b0;
    end else begin
      doneReg <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            if (byteCount == '0) begin
              doneReg <= 1'b1;
            end else begin
              addrSh   <= startAddr;
              dataLeft <= byteCount;
              cmdIdx   <= '0;
              state    <= ST_SHIFT;
            end
          end
        end
        ST_SHIFT: begin
          if (byteDone) begin
            if (cmdIdx == DATA_IDX) begin
              dataLeft <= dataLeft - COUNT_W'(1);
              state    <= (dataLeft == COUNT_W'(1)) ? ST_FIN : ST_GAP;
            end else begin
              cmdIdx <= cmdIdx + IDX_W'(1);
              state  <= ST_GAP;
            end
          end
        end
        ST_GAP: begin
          if (strobe.loadByte) begin
            state <= ST_SHIFT;
            if (cmdIdx != DATA_IDX) addrSh <= addrSh << 8;
          end
        end
        ST_FIN: begin
          doneReg <= 1'b1;
          state   <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R9: once running, the remaining count moves only when a byte finishes,
  // never because of a new start request.
  p_busy_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_IDLE) |=> ($stable(dataLeft) || $past(byteDone)));

endmodule

// File: rtl/fsr_shift.sv
module fsr_shift
  import fsr_pkg::*;
#(
  parameter int CLK_DIV = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  fsr_strobe_t strobe,
  input  logic        miso,
  input  logic        dataReady,
  output logic        csN,
  output logic        sclk,
  output logic        mosi,
  output logic [7:0]  dataOut,
  output logic        dataValid,
  output logic        byteDone,
  output logic        slotFree
);

  localparam int HALF  = CLK_DIV / 2;
  localparam int DIV_W = $clog2(HALF) + 1;

  logic       active;
  logic       tick;
  logic [7:0] txSh;
  logic [7:0] rxSh;
  logic [2:0] bitCnt;
  logic       csNReg;
  logic       sclkReg;
  logic       byteDoneReg;
  logic [7:0] outReg;
  logic       validReg;

  // Half-period timer: a divide by two needs no counter.
  generate
    if (HALF == 1) begin : g_fast
      assign tick = 1'b1;
    end else begin : g_count
      logic [DIV_W-1:0] divCnt;
      always_ff @(posedge clk) begin
        if (!rst_n) divCnt <= '0;
        else if (strobe.loadByte || !active || tick) divCnt <= '0;
        else divCnt <= divCnt + DIV_W'(1);
      end
      assign tick = (divCnt == DIV_W'(HALF - 1));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      csNReg      <= 1'b1;
      sclkReg     <= 1'b0;
      active      <= 1'b0;
      txSh        <= '0;
      rxSh        <= '0;
      bitCnt      <= '0;
      byteDoneReg <= 1'b0;
      outReg      <= '0;
      validReg    <= 1'b0;
    end else begin
      byteDoneReg <= 1'b0;

      if (strobe.csHigh)     csNReg <= 1'b1;
      else if (strobe.csLow) csNReg <= 1'b0;

      if (strobe.loadByte) begin
        txSh    <= strobe.txByte;
        bitCnt  <= '0;
        sclkReg <= 1'b0;
        active  <= 1'b1;
      end else if (active && tick) begin
        if (!sclkReg) begin
          sclkReg <= 1'b1;
          rxSh    <= {rxSh[6:0], miso};
        end else begin
          sclkReg <= 1'b0;
          if (bitCnt == 3'd7) begin
            active      <= 1'b0;
            byteDoneReg <= 1'b1;
          end else begin
            txSh   <= {txSh[6:0], 1'b0};
            bitCnt <= bitCnt + 3'd1;
          end
        end
      end

      if (strobe.keepByte) begin
        outReg   <= rxSh;
        validReg <= 1'b1;
      end else if (dataReady) begin
        validReg <= 1'b0;
      end
    end
  end

  assign csN       = csNReg;
  assign sclk      = sclkReg;
  assign mosi      = txSh[7];
  assign dataOut   = outReg;
  assign dataValid = validReg;
  assign byteDone  = byteDoneReg;
  assign slotFree  = !validReg || dataReady;

  // R6: the clock only runs while a byte is being shifted.
  p_clock_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> !sclkReg);

  // R6: a finished byte never lands on an unaccepted one.
  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.keepByte |-> !validReg);

  // R5: a byte that is offered and not taken is held unchanged.
  p_hold_output_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (validReg && !dataReady) |=> (validReg && $stable(outReg)));

  // R2: the outgoing bit is steady through the high half of the clock.
  p_mosi_steady_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sclkReg && $past(sclkReg)) |-> $stable(txSh[7]));

endmodule

// File: rtl/flash_stream_reader.sv
module flash_stream_reader
  import fsr_pkg::*;
#(
  parameter int         CLK_DIV   = 4,
  parameter int         ADDR_W    = 24,
  parameter int         COUNT_W   = 16,
  parameter logic [7:0] READ_OP   = 8'h03,
  parameter logic [7:0] FILL_BYTE = 8'h00
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [ADDR_W-1:0]  startAddr,
  input  logic [COUNT_W-1:0] byteCount,
  output logic               busy,
  output logic               done,
  output logic               csN,
  output logic               sclk,
  output logic               mosi,
  input  logic               miso,
  output logic [7:0]         dataOut,
  output logic               dataValid,
  input  logic               dataReady
);

  fsr_strobe_t strobe;
  logic        byteDone;
  logic        slotFree;

  fsr_ctrl #(
    .ADDR_W   (ADDR_W),
    .COUNT_W  (COUNT_W),
    .READ_OP  (READ_OP),
    .FILL_BYTE(FILL_BYTE)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .startAddr(startAddr),
    .byteCount(byteCount),
    .byteDone (byteDone),
    .slotFree (slotFree),
    .strobe   (strobe),
    .busy     (busy),
    .done     (done)
  );

  fsr_shift #(
    .CLK_DIV(CLK_DIV)
  ) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe   (strobe),
    .miso     (miso),
    .dataReady(dataReady),
    .csN      (csN),
    .sclk     (sclk),
    .mosi     (mosi),
    .dataOut  (dataOut),
    .dataValid(dataValid),
    .byteDone (byteDone),
    .slotFree (slotFree)
  );

  // R2: no clock edge outside a command.
  p_cs_clock_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    csN |-> !sclk);

  // R7: completion follows the release of chip select by one cycle.
  p_done_after_cs_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(csN) |=> done);

  // R8: an empty read completes at once with chip select still high.
  p_zero_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && (byteCount == '0)) |=> (done && csN));

endmodule

// File: tb/tb_flash_stream_reader.sv
module tb_flash_stream_reader;

  localparam int CLK_PERIOD = 10;
  localparam int CLK_DIV    = 4;
  localparam int COUNT_W    = 16;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               start = 1'b0;
  logic [23:0]        startAddr = '0;
  logic [COUNT_W-1:0] byteCount = '0;
  logic               busy, done, csN, sclk, mosi;
  logic               miso = 1'b1;
  logic [7:0]         dataOut;
  logic               dataValid;
  logic               dataReady = 1'b1;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_stream_reader #(.CLK_DIV(CLK_DIV), .COUNT_W(COUNT_W)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .startAddr(startAddr),
    .byteCount(byteCount), .busy(busy), .done(done), .csN(csN),
    .sclk(sclk), .mosi(mosi), .miso(miso), .dataOut(dataOut),
    .dataValid(dataValid), .dataReady(dataReady)
  );

  function automatic logic [7:0] memByte(input logic [23:0] a);
    return a[7:0] ^ (a[15:8] * 8'd3) ^ (a[23:16] * 8'd7) ^ 8'h5A;
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // ---------------- flash model ----------------
  int          riseCnt = 0;
  int          csFalls = 0;
  logic [31:0] cmdSh = '0;
  bit          fillerNonZero = 0;
  bit          spacingBad = 0;
  bit          sawExact = 0;
  bit          highBad = 0;
  bit          rogueRise = 0;
  bit          haveRise = 0;
  longint      lastRise = 0;
  int          bitIdx;
  logic [7:0]  curByte;

  always @(negedge csN) begin
    riseCnt  = 0;
    haveRise = 0;
    csFalls++;
    miso = 1'b1;
  end

  always @(posedge sclk) begin
    if (csN) rogueRise = 1;
    else begin
      if (haveRise) begin
        if (longint'($time) - lastRise < longint'(CLK_DIV * CLK_PERIOD)) spacingBad = 1;
        if (longint'($time) - lastRise == longint'(CLK_DIV * CLK_PERIOD)) sawExact = 1;
      end
      lastRise = longint'($time);
      haveRise = 1;
      if (riseCnt < 32) cmdSh = {cmdSh[30:0], mosi};
      else if (mosi) fillerNonZero = 1;
      riseCnt++;
    end
  end

  always @(negedge sclk) begin
    if (!csN) begin
      if (longint'($time) - lastRise != longint'((CLK_DIV/2) * CLK_PERIOD)) highBad = 1;
      if (riseCnt >= 32) begin
        bitIdx  = riseCnt - 32;
        curByte = memByte(cmdSh[23:0] + 24'(bitIdx / 8));
        miso    = curByte[7 - (bitIdx % 8)];
      end else begin
        miso = 1'b1;  // garbage while the command goes out
      end
    end
  end

  // ---------------- transaction runner ----------------
  // mode 0: always ready, 1: random ready, 2: long hold-off then ready
  task automatic runTxn(input logic [23:0] a, input int n, input int mode, input bit poke);
    logic [7:0] rx [0:63];
    int   nrx = 0;
    int   lc = 0;
    int   snap = 0;
    bit   doneSeen = 0;
    logic prevCs = 1'b1;
    logic prev2Cs = 1'b1;
    int   fallsBefore = csFalls;
    int   firstBad = -1;
    fillerNonZero = 0; spacingBad = 0; sawExact = 0; highBad = 0;

    @(negedge clk);
    startAddr = a; byteCount = COUNT_W'(n); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!doneSeen && lc < 20000) begin
      case (mode)
        0: dataReady = 1'b1;
        1: dataReady = 1'($urandom % 2);
        default: dataReady = (lc >= 400);
      endcase
      if (poke && lc == 50) begin
        startAddr = 24'h123456; byteCount = COUNT_W'(3); start = 1'b1;
      end else start = 1'b0;
      if (dataValid && dataReady) begin
        if (nrx < 64) rx[nrx] = dataOut;
        nrx++;
      end
      if (mode == 2 && lc == 200) snap = riseCnt;
      if (mode == 2 && lc == 399) begin
        check(riseCnt == snap, "R6 no clock edges during hold-off", riseCnt, snap);
        check(riseCnt == 40, "R6 stall after first data byte", riseCnt, 40);
        check(sclk == 1'b0, "R6 clock low while stalled", sclk, 0);
        check(dataValid && dataOut == memByte(a), "R5 held byte", dataOut, memByte(a));
      end
      if (done) begin
        doneSeen = 1;
        check(csN && prevCs && !prev2Cs && !busy, "R7 done timing",
              {csN, prevCs, prev2Cs, busy}, 4'b1100);
      end
      prev2Cs = prevCs;
      prevCs  = csN;
      lc++;
      @(negedge clk);
    end
    start = 1'b0;
    check(doneSeen, "R7 done seen", doneSeen, 1);
    check(!done, "R7 done one cycle", done, 0);
    repeat (4) begin
      dataReady = 1'b1;
      if (dataValid) begin
        if (nrx < 64) rx[nrx] = dataOut;
        nrx++;
      end
      @(negedge clk);
    end
    check(cmdSh[31:24] == 8'h03, "R2 opcode", cmdSh[31:24], 8'h03);
    check(cmdSh[23:0] == a, "R2 address", cmdSh[23:0], a);
    check(!rogueRise, "R2 no clock with CS high", rogueRise, 0);
    check(riseCnt == 8 * (4 + n), "R4 clock edge count", riseCnt, 8 * (4 + n));
    check(!fillerNonZero, "R4 filler is zero", fillerNonZero, 0);
    check(nrx == n, "R3 R6 byte count delivered", nrx, n);
    for (int k = 0; k < n && k < 64; k++)
      if (firstBad < 0 && rx[k] != memByte(a + 24'(k))) firstBad = k;
    if (firstBad >= 0)
      check(0, "R5 data order", rx[firstBad], memByte(a + 24'(firstBad)));
    else
      check(1, "R5 data order", 0, 0);
    check(!spacingBad && sawExact && !highBad, "R10 clock timing",
          {spacingBad, sawExact, highBad}, 3'b010);
    check(csFalls == fallsBefore + 1, "R9 single CS period", csFalls, fallsBefore + 1);
    if (poke) begin
      repeat (20) @(negedge clk);
      check(csN && !busy && csFalls == fallsBefore + 1, "R9 ignored start not run",
            csFalls, fallsBefore + 1);
    end
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  // ---------------- main ----------------
  initial begin
    int seedVal;
    int fallsBefore;
    seedVal = $urandom(32'h0000C0DE);

    repeat (3) @(negedge clk);
    check(csN && !sclk && !busy && !done && !dataValid, "R1 reset state",
          {csN, sclk, busy, done, dataValid}, 5'b10000);
    rst_n = 1'b1;
    @(negedge clk);
    check(csN && !sclk && !busy && !done && !dataValid, "R1 after reset",
          {csN, sclk, busy, done, dataValid}, 5'b10000);

    // R8: empty read
    fallsBefore = csFalls;
    startAddr = 24'h00ABCD; byteCount = '0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(done && csN && !busy, "R8 zero count done", {done, csN, busy}, 3'b110);
    @(negedge clk);
    check(!done && csFalls == fallsBefore, "R8 no CS activity", csFalls, fallsBefore);

    // directed cases
    runTxn(24'h000100, 1, 0, 0);          // single byte
    runTxn(24'hFFFFFE, 5, 0, 0);          // address wrap
    runTxn(24'h3C5A00, 6, 2, 0);          // R6 long hold-off
    runTxn(24'h0A0B0C, 8, 1, 1);          // R9 start while busy

    // random mix
    for (int i = 0; i < 10; i++) begin
      logic [23:0] ra;
      int rn, rm;
      ra = 24'($urandom);
      rn = 1 + int'($urandom % 24);
      rm = int'($urandom % 2);
      runTxn(ra, rn, rm, 0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule